// File: doc/BRIEF.md
# Receive Timeout Counter Controller

This block governs a down counter that can serve either as a general-purpose interval counter or as a receive-idle watchdog. In its normal mode, software start and stop strobes load, restart and halt the count, and the counter reloads itself from a preload value each time it expires. A pulse reports each expiry on a counter-ready flag, which feeds an interrupt status register.

In timeout mode, the receive path owns the counter. The start and stop strobes are ignored. Each character moved from the receive shifter into the receive FIFO reloads the preload value and restarts the count. When no character arrives before the count reaches zero, the counter stops at zero and raises the ready flag. This signals that the receive line has gone quiet.

Entering timeout mode halts the counter and clears the flag. Leaving it returns control to software but leaves the count running and any pending flag set. A stop strobe issued afterwards clears the flag.

Top module: `rx_tmo_counter`

## Requirements
- R1: After reset the count is 0, the counter is not running, timeout mode is off and the ready flag is clear.
- R2: In normal mode, a start strobe loads the preload value and sets the counter running. A start issued while the counter is already running reloads the count.
- R3: While running, the count drops by one on each cycle with the tick input high. It holds on cycles without a tick, and it holds while the counter is stopped.
- R4: In normal mode, a tick that finds a running count of 1 or 0 is an expiry. An expiry sets the ready flag, reloads the preload value and keeps the counter running, so a preload of 0 or 1 expires on every tick.
- R5: In normal mode, a stop strobe clears the running state and the ready flag and keeps the count. Stop takes priority over a start in the same cycle.
- R6: A timeout-on strobe sets timeout mode, stops the counter and clears the ready flag, and the count is kept. It takes priority over every other strobe in the same cycle, including timeout-off.
- R7: In timeout mode, start and stop strobes change neither the count, the running state nor the ready flag.
- R8: In timeout mode, a character-transferred strobe loads the preload value and sets the counter running. It takes priority over a tick in the same cycle, and it does not touch the ready flag.
- R9: In timeout mode, an expiry sets the ready flag, leaves the count at 0 and stops the counter until the next character-transferred strobe.
- R10: A timeout-off strobe clears timeout mode without changing the running state, the count or the ready flag. Start and stop strobes in the same cycle are still judged as in timeout mode.
- R11: Once timeout mode has been left, a stop strobe clears a ready flag that is still pending from the timeout mode.
- R12: In normal mode, a character-transferred strobe has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_i | input | 1 | Prescaled count enable, one cycle per count step |
| preload_i | input | CNT_W | Value loaded on start, on character transfer and on normal-mode expiry |
| start_i | input | 1 | Software start-counter strobe |
| stop_i | input | 1 | Software stop-counter strobe |
| tmo_on_i | input | 1 | Enter timeout mode strobe |
| tmo_off_i | input | 1 | Leave timeout mode strobe |
| rx_xfer_i | input | 1 | A received character has been written into the receive FIFO |
| count_o | output | CNT_W | Current count |
| running_o | output | 1 | Counter is counting |
| tmo_mode_o | output | 1 | Timeout mode is active |
| cnt_ready_o | output | 1 | Counter-ready flag for interrupt status |

## Verification
Normal-mode runs use preloads of 3, 5 and 1, with gaps between ticks. These runs separate a true decrement from a hold, and show the reload-and-continue behaviour on expiry. Command strobes are sent during timeout mode to show they have no effect, and transfer strobes are sent in normal mode for the same reason. A transfer and a tick in the same cycle shows that the load wins. Mode-change strobes combined with stops and with each other fix the priority order. Leaving timeout mode with the flag pending, and then stopping, shows that the flag survives the mode change and clears only on the later stop.

// File: rtl/tmo_pkg.sv
// Package: shared control bundle for the receive timeout counter.
// Assumes: consumers agree that load and halt never assert together.
package tmo_pkg;
    typedef struct packed {
        logic load;     // load preload and run
        logic halt;     // stop counting
        logic clr_rdy;  // clear the ready flag
    } tmo_ctl_t;
endpackage

// File: rtl/tmo_mode_ctl.sv
// Module: tmo_mode_ctl
// Holds the timeout-mode state and turns the raw strobes into one control
// bundle for the counter and the flag. Strobes are weighed against the mode
// held before this edge. Timeout-on has priority over everything, and stop
// has priority over start.
// Assumes: strobes are single-cycle and synchronous to clk.
module tmo_mode_ctl
    import tmo_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     start_i,
    input  logic     stop_i,
    input  logic     tmo_on_i,
    input  logic     tmo_off_i,
    input  logic     rx_xfer_i,
    output logic     mode_o,
    output tmo_ctl_t ctl_o
);
    logic mode_q;

    // Mode register: timeout-on sets it, timeout-off clears it, and on wins.
    always_ff @(posedge clk) begin
        if (!rst_n)         mode_q <= 1'b0;
        else if (tmo_on_i)  mode_q <= 1'b1;
        else if (tmo_off_i) mode_q <= 1'b0;
    end

    // Control decode: the owner of the counter depends on the current mode.
    always_comb begin
        ctl_o.halt    = tmo_on_i | (~mode_q & stop_i);
        ctl_o.clr_rdy = tmo_on_i | (~mode_q & stop_i);
        if (tmo_on_i)    ctl_o.load = 1'b0;
        else if (mode_q) ctl_o.load = rx_xfer_i;
        else             ctl_o.load = start_i & ~stop_i;
    end

    assign mode_o = mode_q;

    assert_enter_mode_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_on_i |=> mode_q);
    assert_leave_mode_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo_off_i && !tmo_on_i) |=> !mode_q);
endmodule

// File: rtl/tmo_down_cnt.sv
// Module: tmo_down_cnt
// Down counter with load, halt and tick. An expiry happens when a tick finds
// a running count of 1 or 0 with no load or halt in the same cycle. On expiry
// the counter reloads and keeps running, unless hold_zero is set, in which
// case it parks at 0 and stops.
// Assumes: load and halt are never asserted together.
module tmo_down_cnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             load_i,
    input  logic             halt_i,
    input  logic             hold_zero_i,
    input  logic [CNT_W-1:0] preload_i,
    output logic [CNT_W-1:0] count_o,
    output logic             running_o,
    output logic             expire_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] count_q;
    logic             run_q;
    logic             last_step;

    // Expiry detect: this tick ends the current interval.
    assign last_step = (count_q == '0) || (count_q == ONE);
    assign expire_o  = run_q & tick_i & ~load_i & ~halt_i & last_step;

    // Count and run state update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
            run_q   <= 1'b0;
        end else if (halt_i) begin
            run_q   <= 1'b0;
        end else if (load_i) begin
            count_q <= preload_i;
            run_q   <= 1'b1;
        end else if (expire_o) begin
            if (hold_zero_i) begin
                count_q <= '0;
                run_q   <= 1'b0;
            end else begin
                count_q <= preload_i;
            end
        end else if (run_q && tick_i) begin
            count_q <= count_q - ONE;
        end
    end

    assign count_o   = count_q;
    assign running_o = run_q;

    assert_decrement_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && tick_i && !load_i && !halt_i && count_q > ONE)
        |=> count_q == $past(count_q) - ONE);
    assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !load_i && !halt_i) |=> $stable(count_q) && $stable(run_q));
    assert_park_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (expire_o && hold_zero_i) |=> (count_q == '0) && !run_q);
    assert_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (expire_o && !hold_zero_i) |=> run_q && count_q == $past(preload_i));
    assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> run_q && count_q == $past(preload_i));
endmodule

// File: rtl/tmo_ready_flag.sv
// Module: tmo_ready_flag
// Sticky counter-ready flag. Any expiry sets it, and the clear request
// removes it. Clear wins, although the decoder never raises both in one cycle.
// Assumes: clr_i comes from the mode decoder, expire_i from the counter.
module tmo_ready_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic expire_i,
    input  logic clr_i,
    output logic ready_o
);
    logic ready_q;

    // Flag register: set on expiry, cleared on request.
    always_ff @(posedge clk) begin
        if (!rst_n)        ready_q <= 1'b0;
        else if (clr_i)    ready_q <= 1'b0;
        else if (expire_i) ready_q <= 1'b1;
    end

    assign ready_o = ready_q;

    assert_flag_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (expire_i && !clr_i) |=> ready_q);
    assert_flag_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !ready_q);
    assert_flag_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_q && !clr_i) |=> ready_q);
endmodule

// File: rtl/rx_tmo_counter.sv
// Module: rx_tmo_counter (top)
// Receive timeout counter controller. Instantiates the mode decoder, the
// down counter and the ready flag. In timeout mode the counter parks at zero
// on expiry. In normal mode it reloads and keeps running.
// Assumes: tick_i is a one-cycle enable from a prescaler, and all strobes
// are synchronous to clk.
module rx_tmo_counter
    import tmo_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] preload_i,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic             tmo_on_i,
    input  logic             tmo_off_i,
    input  logic             rx_xfer_i,
    output logic [CNT_W-1:0] count_o,
    output logic             running_o,
    output logic             tmo_mode_o,
    output logic             cnt_ready_o
);
    tmo_ctl_t ctl;
    logic     mode;
    logic     expire;

    tmo_mode_ctl u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .stop_i    (stop_i),
        .tmo_on_i  (tmo_on_i),
        .tmo_off_i (tmo_off_i),
        .rx_xfer_i (rx_xfer_i),
        .mode_o    (mode),
        .ctl_o     (ctl)
    );

    tmo_down_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick_i),
        .load_i      (ctl.load),
        .halt_i      (ctl.halt),
        .hold_zero_i (mode),
        .preload_i   (preload_i),
        .count_o     (count_o),
        .running_o   (running_o),
        .expire_o    (expire)
    );

    tmo_ready_flag u_flag (
        .clk      (clk),
        .rst_n    (rst_n),
        .expire_i (expire),
        .clr_i    (ctl.clr_rdy),
        .ready_o  (cnt_ready_o)
    );

    assign tmo_mode_o = mode;

    assert_tmo_on_halts_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_on_i |=> !running_o && !cnt_ready_o && $stable(count_o));
    assert_cmds_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo_mode_o && !tmo_on_i && !rx_xfer_i && !tick_i && (start_i || stop_i))
        |=> $stable(count_o) && $stable(running_o) && $stable(cnt_ready_o));
    assert_off_keeps_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo_mode_o && tmo_off_i && !tmo_on_i && !rx_xfer_i && !tick_i)
        |=> !tmo_mode_o && $stable(running_o) && $stable(cnt_ready_o));
    assert_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!tmo_mode_o && stop_i) |=> !running_o && !cnt_ready_o);
    assert_xfer_ignored_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!tmo_mode_o && rx_xfer_i && !start_i && !stop_i && !tmo_on_i && !tick_i)
        |=> $stable(count_o) && $stable(running_o));
endmodule

// File: tb/rx_tmo_counter_tb.sv
// Bench: a vector table walked by one loop, then directed reset and corner tests.
module rx_tmo_counter_tb_top;
    localparam int W = 16;
    localparam int NV = 27;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tick = 1'b0, start = 1'b0, stop = 1'b0;
    logic         ton = 1'b0, toff = 1'b0, xfer = 1'b0;
    logic [W-1:0] pre = '0;
    logic [W-1:0] count;
    logic         running, mode, ready;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    rx_tmo_counter #(.CNT_W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .preload_i(pre),
        .start_i(start), .stop_i(stop), .tmo_on_i(ton), .tmo_off_i(toff),
        .rx_xfer_i(xfer), .count_o(count), .running_o(running),
        .tmo_mode_o(mode), .cnt_ready_o(ready)
    );

    // Row: {start,stop,ton,toff,xfer,tick}, preload, exp count, {run,mode,ready}
    localparam logic [40:0] TBL [NV] = '{
        {6'b100000, 16'd3, 16'd3, 3'b100},  //  0 start
        {6'b000001, 16'd3, 16'd2, 3'b100},  //  1 tick
        {6'b000000, 16'd3, 16'd2, 3'b100},  //  2 no tick, hold
        {6'b000001, 16'd3, 16'd1, 3'b100},  //  3 tick
        {6'b000001, 16'd3, 16'd3, 3'b101},  //  4 expiry, reload
        {6'b000001, 16'd3, 16'd2, 3'b101},  //  5 tick
        {6'b100000, 16'd5, 16'd5, 3'b101},  //  6 restart
        {6'b000010, 16'd9, 16'd5, 3'b101},  //  7 xfer ignored
        {6'b010000, 16'd5, 16'd5, 3'b000},  //  8 stop
        {6'b000001, 16'd5, 16'd5, 3'b000},  //  9 tick while stopped
        {6'b100000, 16'd2, 16'd2, 3'b100},  // 10 start
        {6'b101000, 16'd7, 16'd2, 3'b010},  // 11 tmo on beats start
        {6'b100000, 16'd7, 16'd2, 3'b010},  // 12 start ignored
        {6'b000001, 16'd7, 16'd2, 3'b010},  // 13 tick, not running
        {6'b000011, 16'd2, 16'd2, 3'b110},  // 14 xfer beats tick
        {6'b000001, 16'd2, 16'd1, 3'b110},  // 15 tick
        {6'b010000, 16'd2, 16'd1, 3'b110},  // 16 stop ignored
        {6'b000001, 16'd2, 16'd0, 3'b011},  // 17 timeout expiry parks
        {6'b000001, 16'd2, 16'd0, 3'b011},  // 18 parked
        {6'b100000, 16'd8, 16'd0, 3'b011},  // 19 start ignored
        {6'b000010, 16'd4, 16'd4, 3'b111},  // 20 xfer restarts, flag kept
        {6'b010100, 16'd4, 16'd4, 3'b101},  // 21 off + stop: stop ignored
        {6'b000001, 16'd4, 16'd3, 3'b101},  // 22 still running
        {6'b010000, 16'd4, 16'd3, 3'b000},  // 23 stop clears flag
        {6'b100000, 16'd1, 16'd1, 3'b100},  // 24 start preload 1
        {6'b000001, 16'd1, 16'd1, 3'b101},  // 25 expiry every tick
        {6'b001100, 16'd1, 16'd1, 3'b010}   // 26 on beats off
    };

    function automatic string row_tag(int i);
        case (i)
            0, 6, 10:          return "R2";
            1, 2, 3, 5, 9:     return "R3";
            4, 24, 25:         return "R4";
            8:                 return "R5";
            11, 26:            return "R6";
            12, 13, 16, 19:    return "R7";
            14, 15, 20:        return "R8";
            17, 18:            return "R9";
            21, 22:            return "R10";
            23:                return "R11";
            default:           return "R12";
        endcase
    endfunction

    task automatic check(string tag, logic [18:0] exp);
        logic [18:0] act;
        act = {count, running, mode, ready};
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual cnt=%0d run/mode/rdy=%b expected cnt=%0d run/mode/rdy=%b",
                     tag, act[18:3], act[2:0], exp[18:3], exp[2:0]);
        end
    endtask

    task automatic drive(logic [5:0] s, logic [W-1:0] p);
        @(negedge clk);
        {start, stop, ton, toff, xfer, tick} = s;
        pre = p;
        @(posedge clk);
        #1;
        {start, stop, ton, toff, xfer, tick} = '0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1", {16'd0, 3'b000});
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            drive(TBL[i][40:35], TBL[i][34:19]);
            check(row_tag(i), TBL[i][18:0]);
        end

        // Back to normal mode, then reset while running (R1).
        drive(6'b000100, 16'd0);
        drive(6'b100000, 16'd9);
        check("R2", {16'd9, 3'b100});
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        check("R1", {16'd0, 3'b000});
        @(negedge clk);
        rst_n = 1'b1;

        // Preload 0 in normal mode expires on every tick (R4).
        drive(6'b100000, 16'd0);
        check("R4", {16'd0, 3'b100});
        drive(6'b000001, 16'd0);
        check("R4", {16'd0, 3'b101});
        // Start and stop together: stop wins (R5).
        drive(6'b110000, 16'd6);
        check("R5", {16'd0, 3'b000});
        // Stop and tick together: no expiry (R5).
        drive(6'b100000, 16'd1);
        drive(6'b010001, 16'd1);
        check("R5", {16'd1, 3'b000});
        // Timeout mode: xfer on the expiring tick reloads, no flag (R8).
        drive(6'b001000, 16'd1);
        drive(6'b000010, 16'd1);
        drive(6'b000011, 16'd3);
        check("R8", {16'd3, 3'b110});

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule